// File: doc/BRIEF.md
# Outbound Address Window Translator

This block holds a small bank of programmable outbound windows that map ranges of the local processor-bus address space onto a 64-bit PCI address space. Software programs each window through a 32-bit register port: a local base, a PCI base and a size/attribute word. A purely combinational lookup port then takes any 64-bit local address and reports whether a window claims it, which window did, and the PCI address it maps to.

Two windows are fully addressable. A third window exists only as a size/attribute register. It can be written and read back, but it never claims addresses. A change to any field takes effect for lookups in the first cycle after the write edge. The block does not issue bus transactions, handle inbound traffic or decode configuration cycles.

Top module: `obwin_xlate`

## Requirements
- R1: While reset is asserted, and after it is released, every window register reads 0 and no lookup hits until software writes a register.
- R2: Register offsets are as follows. Window 0 uses local-low 0x68, local-high 0x6C, size 0x70, PCI-low 0x74 and PCI-high 0x78. Window 1 uses 0x7C, 0x80, 0x84, 0x88 and 0x8C in the same roles. Window 2 has only a size register, at 0x90. A high half reads bits 63:32 of its 64-bit field. Reads of any other offset, including misaligned ones, return 0.
- R3: Writing one 32-bit half of a 64-bit base leaves the other half unchanged.
- R4: Bit 0 of a size word enables its window. A window whose bit 0 is 0 never hits.
- R5: A window's span is the 32-bit two's complement of its size word with bit 0 forced to 0. An address A hits when base <= A < base + span.
- R6: When that two's complement is zero, the span is 0xFFFFFFFF.
- R7: On a hit, lkPciAddr = PCI base + (A - local base) and lkIdx is the window number. On a miss, lkHit, lkIdx and lkPciAddr are all 0.
- R8: When several windows hit, the lowest-numbered window is reported.
- R9: Window 2's size word is stored and reads back, but window 2 never hits.
- R10: A register write affects lookups from the first cycle after the clock edge that captured it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset, used for both read and write |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| lkAddr | input | 64 | Local address to translate |
| lkHit | output | 1 | A window claims lkAddr |
| lkIdx | output | 2 | Number of the claiming window |
| lkPciAddr | output | 64 | Translated PCI address |

## Verification
The assertions assume the following about the inputs:
- regAddr, regWrEn and regWrData are stable around the clock edge.
- A read-back check needs regAddr to name the same register in the cycle after the write.
- Reset is asserted from time zero.

The bench drives every input on the falling edge. It holds regAddr on the written register only when it intends to read it back, and it begins with reset low. Lookups use chosen addresses at the edges of each window: the base, the last byte, one past the end, and one below the base.

// File: rtl/obwin_pkg.sv
package obwin_pkg;
  localparam int NUM_WIN      = 3;
  localparam int NUM_ADDR_WIN = 2;
  localparam int ADDR_W       = 64;
  localparam int DATA_W       = 32;
  localparam int OFF_W        = 8;
  localparam int IDX_W        = $clog2(NUM_WIN);
  localparam int FIELDS       = 5;
  localparam int unsigned BANK_OFF = 32'h68;
  localparam int unsigned BANK_END = BANK_OFF + NUM_ADDR_WIN * FIELDS * 4;

  typedef enum logic [2:0] {
    FLD_NONE, FLD_LCL_LO, FLD_LCL_HI, FLD_SIZE, FLD_PCI_LO, FLD_PCI_HI
  } fld_e;

  typedef struct packed {
    fld_e             field;
    logic [IDX_W-1:0] win;
  } regSel_t;

  typedef struct packed {
    logic    wrEn;
    regSel_t sel;
  } ctrlStrobe_t;
endpackage

// File: rtl/obwin_ctrl.sv
module obwin_ctrl
  import obwin_pkg::*;
(
  input  logic             regWrEn,
  input  logic [OFF_W-1:0] regAddr,
  output ctrlStrobe_t      wrCmd,
  output regSel_t          rdSel
);
  function automatic regSel_t decodeOff(logic [OFF_W-1:0] off);
    regSel_t     s;
    int unsigned offI;
    int unsigned slot;
    s.field = FLD_NONE;
    s.win   = '0;
    offI    = {{(32-OFF_W){1'b0}}, off};
    if (off[1:0] == 2'b00 && offI >= BANK_OFF && offI < BANK_END) begin
      slot  = (offI - BANK_OFF) >> 2;
      s.win = IDX_W'(slot / FIELDS);
      case (slot % FIELDS)
        0:       s.field = FLD_LCL_LO;
        1:       s.field = FLD_LCL_HI;
        2:       s.field = FLD_SIZE;
        3:       s.field = FLD_PCI_LO;
        default: s.field = FLD_PCI_HI;
      endcase
    end else if (offI == BANK_END) begin
      s.win   = IDX_W'(NUM_ADDR_WIN);
      s.field = FLD_SIZE;
    end
    return s;
  endfunction

  regSel_t curSel;
  assign curSel     = decodeOff(regAddr);
  assign rdSel      = curSel;
  assign wrCmd.sel  = curSel;
  assign wrCmd.wrEn = regWrEn && (curSel.field != FLD_NONE);
endmodule

// File: rtl/obwin_datapath.sv
module obwin_datapath
  import obwin_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       wrCmd,
  input  regSel_t           rdSel,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [ADDR_W-1:0] lkAddr,
  output logic              lkHit,
  output logic [IDX_W-1:0]  lkIdx,
  output logic [ADDR_W-1:0] lkPciAddr
);
  logic [ADDR_W-1:0] lclBase [NUM_ADDR_WIN];
  logic [ADDR_W-1:0] pciBase [NUM_ADDR_WIN];
  logic [DATA_W-1:0] sizeWord [NUM_WIN];
  logic [NUM_ADDR_WIN-1:0] hitVec;
  logic [ADDR_W-1:0] xlat [NUM_ADDR_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_size
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sizeWord[w] <= '0;
      else if (wrCmd.wrEn && wrCmd.sel.field == FLD_SIZE && wrCmd.sel.win == IDX_W'(w))
        sizeWord[w] <= regWrData;
    end
  end

  for (genvar w = 0; w < NUM_ADDR_WIN; w++) begin : g_win
    logic selW;
    logic [DATA_W-1:0] maskW, spanW;
    logic [ADDR_W-1:0] offs;
    assign selW = wrCmd.wrEn && wrCmd.sel.win == IDX_W'(w);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lclBase[w] <= '0;
        pciBase[w] <= '0;
      end else if (selW) begin
        case (wrCmd.sel.field)
          FLD_LCL_LO: lclBase[w][31:0]  <= regWrData;
          FLD_LCL_HI: lclBase[w][63:32] <= regWrData;
          FLD_PCI_LO: pciBase[w][31:0]  <= regWrData;
          FLD_PCI_HI: pciBase[w][63:32] <= regWrData;
          default: ;
        endcase
      end
    end

    assign maskW     = sizeWord[w] & ~DATA_W'(1);
    assign spanW     = (maskW == '0) ? '1 : (~maskW + DATA_W'(1));
    assign offs      = lkAddr - lclBase[w];
    assign hitVec[w] = sizeWord[w][0] && (lkAddr >= lclBase[w])
                       && (offs < {{(ADDR_W-DATA_W){1'b0}}, spanW});
    assign xlat[w]   = pciBase[w] + offs;
  end

  always_comb begin
    lkHit     = 1'b0;
    lkIdx     = '0;
    lkPciAddr = '0;
    for (int w = NUM_ADDR_WIN - 1; w >= 0; w--) begin
      if (hitVec[w]) begin
        lkHit     = 1'b1;
        lkIdx     = IDX_W'(w);
        lkPciAddr = xlat[w];
      end
    end
  end

  always_comb begin
    regRdData = '0;
    for (int w = 0; w < NUM_ADDR_WIN; w++) begin
      if (rdSel.win == IDX_W'(w)) begin
        case (rdSel.field)
          FLD_LCL_LO: regRdData = lclBase[w][31:0];
          FLD_LCL_HI: regRdData = lclBase[w][63:32];
          FLD_PCI_LO: regRdData = pciBase[w][31:0];
          FLD_PCI_HI: regRdData = pciBase[w][63:32];
          default: ;
        endcase
      end
    end
    for (int w = 0; w < NUM_WIN; w++)
      if (rdSel.field == FLD_SIZE && rdSel.win == IDX_W'(w)) regRdData = sizeWord[w];
  end
endmodule

// File: rtl/obwin_xlate.sv
module obwin_xlate
  import obwin_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [OFF_W-1:0]  regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [ADDR_W-1:0] lkAddr,
  output logic              lkHit,
  output logic [IDX_W-1:0]  lkIdx,
  output logic [ADDR_W-1:0] lkPciAddr
);
  ctrlStrobe_t wrCmd;
  regSel_t     rdSel;

  obwin_ctrl u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .wrCmd   (wrCmd),
    .rdSel   (rdSel)
  );

  obwin_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wrCmd     (wrCmd),
    .rdSel     (rdSel),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .lkAddr    (lkAddr),
    .lkHit     (lkHit),
    .lkIdx     (lkIdx),
    .lkPciAddr (lkPciAddr)
  );
endmodule

// File: rtl/obwin_xlate_chk.sv
module obwin_xlate_chk
  import obwin_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [OFF_W-1:0]  regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic              lkHit,
  input logic [IDX_W-1:0]  lkIdx,
  input logic [ADDR_W-1:0] lkPciAddr
);
  AST_RESET_NO_HIT: assert property (@(posedge clk) !rstN |=> !lkHit); // R1

  AST_SIZE_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 8'h84) |=> (regAddr != 8'h84 || regRdData == $past(regWrData))); // R2

  AST_DISABLED_WIN0: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 8'h70 && !regWrData[0]) |=> !(lkHit && lkIdx == 2'd0)); // R4

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !lkHit |-> (lkIdx == '0 && lkPciAddr == '0)); // R7

  AST_WIN2_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> (lkIdx < IDX_W'(NUM_ADDR_WIN))); // R9
endmodule

bind obwin_xlate obwin_xlate_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .lkHit     (lkHit),
  .lkIdx     (lkIdx),
  .lkPciAddr (lkPciAddr)
);

// File: tb/obwin_xlate_test.sv
module obwin_xlate_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [63:0] lkAddr = '0;
  logic        lkHit;
  logic [1:0]  lkIdx;
  logic [63:0] lkPciAddr;

  int checkCnt = 0;
  int failCnt  = 0;

  typedef struct {
    bit          isRead;
    logic [31:0] rdExp;
    bit          hitExp;
    logic [1:0]  idxExp;
    logic [63:0] pciExp;
    string       tag;
  } expItem_t;
  expItem_t sbQ[$];

  always #2 clk = ~clk;

  obwin_xlate uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .lkAddr(lkAddr),
    .lkHit(lkHit), .lkIdx(lkIdx), .lkPciAddr(lkPciAddr)
  );

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0; regAddr = 8'hFC;
  endtask

  task automatic expectRead(input logic [7:0] a, input logic [31:0] e, input string tag);
    expItem_t it;
    @(negedge clk);
    regAddr = a;
    it.isRead = 1; it.rdExp = e; it.hitExp = 0; it.idxExp = 0; it.pciExp = 0; it.tag = tag;
    sbQ.push_back(it);
  endtask

  task automatic expectLookup(input logic [63:0] a, input bit h, input logic [1:0] i,
                              input logic [63:0] p, input string tag);
    expItem_t it;
    @(negedge clk);
    lkAddr = a;
    it.isRead = 0; it.rdExp = 0; it.hitExp = h; it.idxExp = i; it.pciExp = p; it.tag = tag;
    sbQ.push_back(it);
  endtask

  task automatic expectMiss(input logic [63:0] a, input string tag);
    expectLookup(a, 1'b0, 2'd0, 64'd0, tag);
  endtask

  // monitor: pops one expected item per falling edge and compares
  initial begin
    forever begin
      @(negedge clk); #1;
      if (sbQ.size() > 0) begin
        expItem_t it;
        it = sbQ.pop_front();
        checkCnt++;
        if (it.isRead) begin
          if (regRdData !== it.rdExp) begin
            failCnt++;
            $display("FAIL %s: read got %h expected %h", it.tag, regRdData, it.rdExp);
          end
        end else if (lkHit !== it.hitExp || lkIdx !== it.idxExp || lkPciAddr !== it.pciExp) begin
          failCnt++;
          $display("FAIL %s: lookup got hit=%b idx=%0d pci=%h expected hit=%b idx=%0d pci=%h",
                   it.tag, lkHit, lkIdx, lkPciAddr, it.hitExp, it.idxExp, it.pciExp);
        end
      end
    end
  end

  initial begin
    #800000;
    checkCnt++; failCnt++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    // R1 state during reset
    expectRead(8'h70, 32'h0, "R1 size0 in reset");
    expectMiss(64'h0, "R1 no hit in reset");
    @(negedge clk); rstN = 1'b1;
    expectRead(8'h6C, 32'h0, "R1 lcl hi after reset");
    expectRead(8'h90, 32'h0, "R1 size2 after reset");
    expectMiss(64'h0, "R1 no hit after reset");

    // window 0: local 1_8000_0000, pci C000_0000, span 0x1000_0000
    regWrite(8'h68, 32'h8000_0000);
    regWrite(8'h6C, 32'h0000_0001);
    regWrite(8'h74, 32'hC000_0000);
    regWrite(8'h78, 32'h0000_0000);
    regWrite(8'h70, 32'hF000_0001);
    expectLookup(64'h1_8000_0000, 1, 0, 64'hC000_0000, "R5 base hits");
    expectLookup(64'h1_8000_1234, 1, 0, 64'hC000_1234, "R7 translate");
    expectLookup(64'h1_8FFF_FFFF, 1, 0, 64'hCFFF_FFFF, "R5 last byte");
    expectMiss(64'h1_9000_0000, "R5 one past end");
    expectMiss(64'h1_7FFF_FFFF, "R5 below base");
    expectRead(8'h6C, 32'h1, "R2 high half");
    expectRead(8'h68, 32'h8000_0000, "R2 low half");
    expectRead(8'h70, 32'hF000_0001, "R2 size0");

    // R3 half write; R10 immediate effect
    regWrite(8'h6C, 32'h0000_0002);
    expectLookup(64'h2_8000_0010, 1, 0, 64'hC000_0010, "R10 new base active next cycle");
    expectRead(8'h68, 32'h8000_0000, "R3 low half kept");
    expectRead(8'h6C, 32'h2, "R3 high half written");

    // R4 disable
    regWrite(8'h70, 32'hF000_0000);
    expectMiss(64'h2_8000_0010, "R4 disabled window");
    expectRead(8'h70, 32'hF000_0000, "R4 size stored");

    // R6 zero mask gives full span
    regWrite(8'h70, 32'h0000_0001);
    expectLookup(64'h3_7FFF_FFFE, 1, 0, 64'h1_BFFF_FFFE, "R6 span 0xFFFFFFFF last");
    expectMiss(64'h3_7FFF_FFFF, "R6 end of span");

    // R5 bit 0 excluded from span
    regWrite(8'h70, 32'hFFFF_0003);
    expectLookup(64'h2_8000_FFFD, 1, 0, 64'hC000_FFFD, "R5 odd mask last byte");
    expectMiss(64'h2_8000_FFFE, "R5 odd mask end");

    // R8 priority with window 1 overlapping
    regWrite(8'h70, 32'hF000_0001);
    regWrite(8'h7C, 32'h8800_0000);
    regWrite(8'h80, 32'h0000_0002);
    regWrite(8'h88, 32'h0000_0000);
    regWrite(8'h8C, 32'h0000_0010);
    regWrite(8'h84, 32'hE000_0001);
    expectLookup(64'h2_8800_0004, 1, 0, 64'hC800_0004, "R8 overlap win0 wins");
    expectLookup(64'h2_9000_0000, 1, 1, 64'h10_0800_0000, "R8 win1 alone");
    expectRead(8'h8C, 32'h10, "R2 win1 pci high");
    expectRead(8'h84, 32'hE000_0001, "R2 win1 size");

    // R9 window 2
    regWrite(8'h90, 32'hFFFF_FF01);
    expectRead(8'h90, 32'hFFFF_FF01, "R9 size2 stored");
    expectMiss(64'h0, "R9 window2 no hit at 0");
    expectMiss(64'h4_0000_0000, "R9 window2 no hit high");

    // R2 unmapped offsets
    expectRead(8'h94, 32'h0, "R2 unmapped");
    expectRead(8'h6A, 32'h0, "R2 misaligned");

    // R1 reset again clears everything
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    expectRead(8'h8C, 32'h0, "R1 cleared pci high");
    expectMiss(64'h2_9000_0000, "R1 cleared window");

    @(negedge clk); @(negedge clk);
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule